// File: doc/BRIEF.md
# Single-Channel DMA Bus Takeover Controller

This block lets one peripheral move a block of words to or from memory without the processor copying each word. Software loads a start address, a word count and a direction while the channel is idle. When the peripheral raises its transfer request, the controller asks the processor for the system bus. It takes the bus only after the processor grants it. While it owns the bus, it drives the memory address and the read or write strobe and signals the peripheral that it may move data.

Bus ownership appears as three switch enables. One connects the processor to the shared address and data buses. One connects the controller's address driver. One connects the peripheral's data port. The processor switch is closed whenever the controller does not own the bus, and it is never closed together with either of the other two. The processor may take the bus back in the middle of a block. The controller then lets go on the next cycle, keeps its request raised, and continues at the same address once the grant returns. When the last word moves, the controller hands the bus back and raises a done flag.

Top module: `dma_bus_ctrl`

## Requirements
- R1: After reset, bus_req_o, xfer_gnt_o, sw_dmac_o, sw_periph_o, mem_we_o, mem_re_o and done_o are low and sw_cpu_o is high.
- R2: A cfg_load_i pulse while idle stores cfg_addr_i, cfg_count_i and cfg_dir_i and clears done_o.
- R3: With a nonzero count, xfer_req_i high makes bus_req_o high on the next cycle, while sw_cpu_o stays high and xfer_gnt_o stays low.
- R4: Ownership begins only in the cycle after bus_gnt_i is sampled high while requesting. During ownership sw_cpu_o is low and sw_dmac_o, sw_periph_o and xfer_gnt_o are high.
- R5: During ownership mem_addr_o equals the start address plus the number of words already moved, modulo 2^AW. cfg_dir_i = 0 means peripheral to memory (mem_we_o high). cfg_dir_i = 1 means memory to peripheral (mem_re_o high). One word moves in each owned cycle in which both bus_gnt_i and xfer_req_i are high.
- R6: On the cycle after the last word moves, done_o is high, bus_req_o and xfer_gnt_o are low, and sw_cpu_o is high.
- R7: If bus_gnt_i is low during an owned cycle while xfer_req_i stays high, then on the next cycle the controller no longer owns the bus and bus_req_o stays high. When the grant returns, the controller resumes at the address where it stopped.
- R8: If xfer_req_i drops during an owned cycle before the block ends, the bus is released and bus_req_o is low on the next cycle. A later request continues the same block.
- R9: With a zero count, xfer_req_i is ignored and bus_req_o stays low.
- R10: sw_cpu_o is never high in the same cycle as sw_dmac_o or sw_periph_o. xfer_gnt_o, mem_we_o and mem_re_o are high only when the bus was granted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load pulse for the channel registers (taken only while idle) |
| cfg_addr_i | input | AW | Start address |
| cfg_count_i | input | CW | Number of words in the block |
| cfg_dir_i | input | 1 | 0 = peripheral to memory, 1 = memory to peripheral |
| xfer_req_i | input | 1 | Transfer request from the peripheral |
| xfer_gnt_o | output | 1 | Transfer grant to the peripheral |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_gnt_i | input | 1 | Bus grant from the processor |
| mem_addr_o | output | AW | Memory address during ownership |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| sw_cpu_o | output | 1 | Processor-to-bus switch enable |
| sw_dmac_o | output | 1 | Controller-to-bus switch enable |
| sw_periph_o | output | 1 | Peripheral-to-bus switch enable |
| done_o | output | 1 | Block complete |

## Verification
Two events can fall in the same cycle: the processor withdrawing its grant, and the peripheral's word step, including the step that would be the last of the block. The sweep drops bus_gnt_i exactly on an owned cycle, both mid-block and on the final word. It then checks that no word moved, that the bus was released with the request still raised, and that the next owned cycle shows the unchanged address. The peripheral pausing on the final word is provoked in the same way. The bench then checks that done_o waits until the word has actually moved.

// File: rtl/dma_bus_pkg.sv
package dma_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } dma_st_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          dir_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          count_zero_o,
  output logic          count_one_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= 1'b0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      count_q <= count_i;
      dir_q   <= dir_i;
    end else if (step_i) begin
      addr_q  <= addr_q + AW'(1);
      count_q <= count_q - CNT_ONE;
    end
  end

  assign addr_o       = addr_q;
  assign dir_o        = dir_q;
  assign count_zero_o = (count_q == '0);
  assign count_one_o  = (count_q == CNT_ONE);

  p_step_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_q == AW'($past(addr_q) + AW'(1)))
                         && (count_q == CW'($past(count_q) - CNT_ONE)));

  p_no_step_at_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !count_zero_o);
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic xfer_req_i,
  input  logic bus_gnt_i,
  input  logic count_zero_i,
  input  logic count_one_i,
  output logic idle_o,
  output logic bus_req_o,
  output logic own_o,
  output logic step_o,
  output logic done_o
);
  dma_st_e st_q, st_d;
  logic    done_q;
  logic    last;

  assign step_o = (st_q == ST_XFER) && bus_gnt_i && xfer_req_i;
  assign last   = step_o && count_one_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (xfer_req_i && !count_zero_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!xfer_req_i)    st_d = ST_IDLE;
        else if (bus_gnt_i) st_d = ST_XFER;
      end
      ST_XFER: begin
        if (!bus_gnt_i)       st_d = xfer_req_i ? ST_REQ : ST_IDLE;
        else if (!xfer_req_i) st_d = ST_IDLE;
        else if (last)        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (last)        done_q <= 1'b1;
      else if (load_i) done_q <= 1'b0;
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign bus_req_o = (st_q != ST_IDLE);
  assign own_o     = (st_q == ST_XFER);
  assign done_o    = done_q;

  p_own_after_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_o) |-> $past(bus_gnt_i) && $past(bus_req_o));

  p_release_keep_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_o && !bus_gnt_i && xfer_req_i) |=> !own_o && bus_req_o);

  p_pause_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_o && !xfer_req_i) |=> !bus_req_o);

  p_zero_count_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && count_zero_i && !load_i) |=> !bus_req_o);
endmodule

// File: rtl/dma_bus_switch.sv
module dma_bus_switch #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          own_i,
  input  logic          dir_i,
  input  logic [AW-1:0] addr_i,
  output logic          sw_cpu_o,
  output logic          sw_dmac_o,
  output logic          sw_periph_o,
  output logic          xfer_gnt_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o
);
  assign sw_cpu_o    = !own_i;
  assign sw_dmac_o   = own_i;
  assign sw_periph_o = own_i;
  assign xfer_gnt_o  = own_i;
  // Address bus is parked at zero while the processor owns it.
  assign mem_addr_o  = own_i ? addr_i : '0;
  assign mem_we_o    = own_i && !dir_i;
  assign mem_re_o    = own_i && dir_i;

  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i |-> $onehot({mem_we_o, mem_re_o}));
endmodule

// File: rtl/dma_bus_ctrl.sv
module dma_bus_ctrl #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic          cfg_dir_i,
  input  logic          xfer_req_i,
  output logic          xfer_gnt_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          sw_cpu_o,
  output logic          sw_dmac_o,
  output logic          sw_periph_o,
  output logic          done_o
);
  logic          idle, own, step, load;
  logic          count_zero, count_one, dir;
  logic [AW-1:0] addr;

  assign load = cfg_load_i && idle;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .addr_i       (cfg_addr_i),
    .count_i      (cfg_count_i),
    .dir_i        (cfg_dir_i),
    .step_i       (step),
    .addr_o       (addr),
    .dir_o        (dir),
    .count_zero_o (count_zero),
    .count_one_o  (count_one)
  );

  dma_bus_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .xfer_req_i   (xfer_req_i),
    .bus_gnt_i    (bus_gnt_i),
    .count_zero_i (count_zero),
    .count_one_i  (count_one),
    .idle_o       (idle),
    .bus_req_o    (bus_req_o),
    .own_o        (own),
    .step_o       (step),
    .done_o       (done_o)
  );

  dma_bus_switch #(.AW(AW)) u_sw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .own_i       (own),
    .dir_i       (dir),
    .addr_i      (addr),
    .sw_cpu_o    (sw_cpu_o),
    .sw_dmac_o   (sw_dmac_o),
    .sw_periph_o (sw_periph_o),
    .xfer_gnt_o  (xfer_gnt_o),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o)
  );

  p_switch_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_cpu_o && (sw_dmac_o || sw_periph_o)));

  p_strobe_needs_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_gnt_o || mem_we_o || mem_re_o) |-> $past(bus_gnt_i));

  p_done_returns_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !bus_req_o && sw_cpu_o && !xfer_gnt_o);
endmodule

// File: tb/dma_bus_ctrl_tb.sv
module dma_bus_ctrl_tb;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_dir = 1'b0;
  logic          xfer_req = 1'b0;
  logic          bus_gnt = 1'b0;
  logic          xfer_gnt, bus_req, mem_we, mem_re, sw_cpu, sw_dmac, sw_periph, done;
  logic [AW-1:0] mem_addr;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  dma_bus_ctrl #(.AW(AW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_addr_i(cfg_addr),
    .cfg_count_i(cfg_count), .cfg_dir_i(cfg_dir), .xfer_req_i(xfer_req),
    .xfer_gnt_o(xfer_gnt), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .sw_cpu_o(sw_cpu), .sw_dmac_o(sw_dmac), .sw_periph_o(sw_periph), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cpu_owns(input string tag);
    chk(bus_req == 1'b0, {tag, " bus_req"}, bus_req, 0);
    chk(sw_cpu == 1'b1 && sw_dmac == 1'b0 && sw_periph == 1'b0, {tag, " switches"},
        {sw_cpu, sw_dmac, sw_periph}, 3'b100);
    chk(xfer_gnt == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, {tag, " strobes"},
        {xfer_gnt, mem_we, mem_re}, 0);
  endtask

  task automatic dma_owns(input logic [AW-1:0] ea, input bit dir, input string tag);
    chk(sw_cpu == 1'b0 && sw_dmac == 1'b1 && sw_periph == 1'b1 && xfer_gnt == 1'b1,
        "R4 ownership", {sw_cpu, sw_dmac, sw_periph, xfer_gnt}, 4'b0111);
    chk(mem_addr == ea, {tag, " address"}, mem_addr, ea);
    chk(mem_we == !dir && mem_re == dir, {tag, " direction"}, {mem_we, mem_re},
        dir ? 2'b01 : 2'b10);
  endtask

  task automatic run_block(input logic [AW-1:0] start, input int cnt, input bit dir,
                           input int gdly, input int drop_at, input int pause_at);
    int  k;
    bit  dropped, paused;
    logic [AW-1:0] ea;
    @(negedge clk);
    cfg_load = 1'b1; cfg_addr = start; cfg_count = CW'(cnt); cfg_dir = dir;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(done == 1'b0, "R2 done cleared", done, 0);
    cpu_owns("R2 idle");
    xfer_req = 1'b1; bus_gnt = 1'b0;
    @(negedge clk);
    if (cnt == 0) begin
      chk(bus_req == 1'b0, "R9 zero count", bus_req, 0);
      bus_gnt = 1'b1;
      @(negedge clk);
      cpu_owns("R9 zero count");
      xfer_req = 1'b0; bus_gnt = 1'b0;
      return;
    end
    chk(bus_req == 1'b1 && sw_cpu == 1'b1 && xfer_gnt == 1'b0, "R3 request",
        {bus_req, sw_cpu, xfer_gnt}, 3'b110);
    for (int i = 0; i < gdly; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b1 && sw_dmac == 1'b0 && sw_cpu == 1'b1, "R4 wait grant",
          {bus_req, sw_dmac, sw_cpu}, 3'b101);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    k = 0; dropped = 1'b0; paused = 1'b0;
    while (k < cnt) begin
      ea = start + AW'(k);
      dma_owns(ea, dir, "R5");
      if (k == drop_at && !dropped) begin
        dropped = 1'b1;
        bus_gnt = 1'b0;
        @(negedge clk);
        chk(sw_dmac == 1'b0 && sw_periph == 1'b0 && sw_cpu == 1'b1 && xfer_gnt == 1'b0,
            "R7 released", {sw_cpu, sw_dmac, sw_periph, xfer_gnt}, 4'b1000);
        chk(bus_req == 1'b1 && done == 1'b0, "R7 request held", {bus_req, done}, 2'b10);
        bus_gnt = 1'b1;
        @(negedge clk);
        chk(mem_addr == ea, "R7 resume address", mem_addr, ea);
        continue;
      end
      if (k == pause_at && !paused) begin
        paused = 1'b1;
        xfer_req = 1'b0;
        @(negedge clk);
        cpu_owns("R8 pause");
        chk(done == 1'b0, "R8 not done", done, 0);
        xfer_req = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b1 && sw_dmac == 1'b0, "R8 re-request", {bus_req, sw_dmac}, 2'b10);
        @(negedge clk);
        chk(mem_addr == ea, "R8 resume address", mem_addr, ea);
        continue;
      end
      @(negedge clk);
      k++;
    end
    chk(done == 1'b1, "R6 done", done, 1);
    cpu_owns("R6 handback");
    @(negedge clk);
    cpu_owns("R9 spent count");
    xfer_req = 1'b0; bus_gnt = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(!(sw_cpu && (sw_dmac || sw_periph)), "R10 exclusive switches",
          {sw_cpu, sw_dmac, sw_periph}, 3'b100);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cpu_owns("R1 reset");
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_owns("R1 after reset");

    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 5; c++)
        for (int g = 0; g < 3; g++)
          for (int v = 0; v < 4; v++) begin
            logic [AW-1:0] st;
            int drop_at, pause_at;
            st = (v == 0) ? 16'hFFFE : AW'(16'h0100 * c + 16'h0010 * g + v);
            drop_at  = (v == 1) ? c / 2 : (v == 3 ? c - 1 : -1);
            pause_at = (v == 2) ? c - 1 : -1;
            run_block(st, c, bit'(d), g, drop_at, pause_at);
          end

    run_block(16'hFFF0, 255, 1'b0, 1, 100, 254);
    run_block(16'h1234, 255, 1'b1, 0, 254, 7);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule